// File: doc/BRIEF.md
# UART Receive FIFO Time-out Detector

This block watches the receive side of a UART that buffers characters in a FIFO. It raises a level time-out flag when characters have sat in the FIFO without the host collecting them, and no new character has arrived, for four whole character times. Each character time counts every bit of the frame: start, data, parity and stop. The deserializer and the FIFO storage are outside the block. It sees only a 16x oversample baud tick, the programmed frame length in bits, a FIFO-mode enable, a FIFO-not-empty flag, a strobe at the middle of the first stop bit of each received character, and a strobe for each host read of the holding register.

The count restarts from zero on every received character and on every host read. A host read clears the flag. A new character restarts the count but leaves a raised flag in place. The flag is meant for the interrupt logic, where this cause ranks below receive-data-available and above transmitter-empty.

Top module: `rx_timeout_det`

## Requirements
- R1: After reset `timeout` is 0 and the tick count is zero.
- R2: With `fifo_mode`=1 and `fifo_nonempty`=1 held, and no strobe on `stop_mid` or `host_read`, `timeout` is 0 after 4*16*L-1 accepted baud ticks following the last restart and 1 after the 4*16*L-th. L is `char_bits`, and the flag shows on the clock edge that accepts that tick.
- R3: While `fifo_mode`=0 or `fifo_nonempty`=0, the count is held at zero and `timeout` is 0 one cycle later, including a flag that was already set.
- R4: A `host_read` pulse clears `timeout` on that edge and restarts the count from zero.
- R5: A `stop_mid` pulse restarts the count from zero but does not clear a `timeout` that is already set.
- R6: When `host_read` and `stop_mid` pulse in the same cycle, and a baud tick in that cycle would have completed the interval, the count restarts and `timeout` stays 0.
- R7: Clock cycles with `baud_tick`=0 do not advance the count.
- R8: A `char_bits` value of 0 is treated as 1, so the interval is 64 ticks.
- R9: Once set, `timeout` stays 1 through further baud ticks while the enable holds and no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle 16x oversample tick |
| char_bits | input | LEN_W | Frame length in bits, start through stop |
| fifo_mode | input | 1 | FIFO mode enabled |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one item |
| stop_mid | input | 1 | Strobe at middle of first stop bit of a received character |
| host_read | input | 1 | Strobe when host reads the holding register |
| timeout | output | 1 | Level time-out flag |

## Verification
On every cycle the assertions check these rules: the count is zero and the flag is low while the block is disarmed, any restart strobe leaves a zero count, a read always drops the flag, the count never passes its limit, and the flag rises only from the last count before the limit. The exact number of ticks before the flag rises can only be shown by the bench's scenarios. The same holds for clamping a zero frame length, ignoring idle cycles, keeping the flag after a late character, and the tie between a read and a new character. For these the bench sweeps every frame length and compares against a limit it computes itself.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  // Number of oversample ticks making up the whole time-out window.
  function automatic int unsigned rxto_tick_limit(input int unsigned bits,
                                                  input int unsigned periods,
                                                  input int unsigned ovs);
    int unsigned eff;
    eff = (bits == 0) ? 1 : bits;
    return periods * ovs * eff;
  endfunction

  // Counter width wide enough for the largest programmable window.
  function automatic int unsigned rxto_cnt_width(input int unsigned len_w,
                                                 input int unsigned periods,
                                                 input int unsigned ovs);
    return $clog2(periods * ovs * ((1 << len_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/rxto_arm.sv
module rxto_arm #(
  parameter int unsigned CW = 10
) (
  input  logic          fifo_mode,
  input  logic          fifo_nonempty,
  input  logic          stop_mid,
  input  logic          host_read,
  input  logic          baud_tick,
  input  logic          flag_q,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] limit,
  output logic          armed,
  output logic          restart,
  output logic          cnt_clear,
  output logic          cnt_adv,
  output logic          flag_set,
  output logic          flag_clear
);
  always_comb begin
    armed      = fifo_mode & fifo_nonempty;
    restart    = stop_mid | host_read;
    cnt_clear  = ~armed | restart;
    cnt_adv    = armed & ~restart & baud_tick & ~flag_q;
    flag_set   = cnt_adv & (cnt == (limit - CW'(1)));
    flag_clear = ~armed | host_read;
  end
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (advance) cnt <= cnt + CW'(1);
  end

  // R4 / R5: any restart leaves a zero count
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (clear) flag <= 1'b0;
    else if (set)   flag <= 1'b1;
  end
endmodule

// File: rtl/rx_timeout_det.sv
module rx_timeout_det #(
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned OVS     = 16,
  parameter int unsigned PERIODS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic [LEN_W-1:0] char_bits,
  input  logic             fifo_mode,
  input  logic             fifo_nonempty,
  input  logic             stop_mid,
  input  logic             host_read,
  output logic             timeout
);
  import rxto_pkg::*;

  localparam int unsigned CW = rxto_cnt_width(LEN_W, PERIODS, OVS);

  logic [CW-1:0] limit;
  logic [CW-1:0] cnt;
  logic armed, restart, cnt_clear, cnt_adv, flag_set, flag_clear;

  always_comb limit = CW'(rxto_tick_limit(32'(char_bits), PERIODS, OVS));

  rxto_arm #(.CW(CW)) u_arm (
    .fifo_mode(fifo_mode), .fifo_nonempty(fifo_nonempty),
    .stop_mid(stop_mid), .host_read(host_read), .baud_tick(baud_tick),
    .flag_q(timeout), .cnt(cnt), .limit(limit),
    .armed(armed), .restart(restart), .cnt_clear(cnt_clear),
    .cnt_adv(cnt_adv), .flag_set(flag_set), .flag_clear(flag_clear)
  );

  rxto_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .advance(cnt_adv), .cnt(cnt)
  );

  rxto_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clear(flag_clear), .set(flag_set), .flag(timeout)
  );

  // R3: disarmed block holds a zero count and a low flag
  p_idle_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_mode && fifo_nonempty) |=> (!timeout && cnt == '0));

  // R4: a host read always drops the flag
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_read |=> !timeout);

  // R2: flag rises only from the last count before the limit, on a tick
  p_rise_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> ($past(cnt) == $past(limit) - CW'(1) && $past(baud_tick)));

  // R9: raised flag persists while armed and unread
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && fifo_mode && fifo_nonempty && !host_read) |=> timeout);

  // R2: count never passes the window
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(char_bits) |-> (cnt <= limit));
endmodule

// File: tb/rx_timeout_det_tb.sv
module rx_timeout_det_tb;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic [LEN_W-1:0] char_bits = '0;
  logic fifo_mode = 1'b0;
  logic fifo_nonempty = 1'b0;
  logic stop_mid = 1'b0;
  logic host_read = 1'b0;
  logic timeout;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_timeout_det #(.LEN_W(LEN_W), .OVS(16), .PERIODS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .char_bits(char_bits),
    .fifo_mode(fifo_mode), .fifo_nonempty(fifo_nonempty),
    .stop_mid(stop_mid), .host_read(host_read), .timeout(timeout)
  );

  function automatic int win(input int l);
    int e;
    e = (l < 1) ? 1 : l;
    return 64 * e;
  endfunction

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (timeout !== exp) begin
      n_fail++;
      $display("FAIL %s: timeout=%b expected=%b", req, timeout, exp);
    end
  endtask

  // one cycle with the given strobes, then sample at the falling edge
  task automatic cyc(input logic t, input logic s, input logic r);
    baud_tick = t; stop_mid = s; host_read = r;
    @(negedge clk);
    baud_tick = 1'b0; stop_mid = 1'b0; host_read = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: timeout=%b expected=finish", timeout);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    fifo_mode = 1'b1; fifo_nonempty = 1'b1;
    // R2 / R8: sweep every frame length, zero clamps to one
    for (int l = 0; l < 16; l++) begin
      char_bits = LEN_W'(l);
      cyc(1'b0, 1'b1, 1'b0);
      ticks(win(l) - 1, 0);
      check(l == 0 ? "R8" : "R2", 1'b0);
      ticks(1, 0);
      check(l == 0 ? "R8" : "R2", 1'b1);
      ticks(5, 0);
      check("R9", 1'b1);
      cyc(1'b0, 1'b0, 1'b1);
      check("R4", 1'b0);
    end

    // R7: idle cycles between ticks do not count
    char_bits = 4'd2;
    cyc(1'b0, 1'b1, 1'b0);
    ticks(win(2) - 1, 2);
    check("R7", 1'b0);
    ticks(1, 0);
    check("R7", 1'b1);

    // R5: late character keeps the flag, restarts the count
    cyc(1'b0, 1'b1, 1'b0);
    check("R5", 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    check("R4", 1'b0);
    ticks(50, 0);
    cyc(1'b0, 1'b1, 1'b0);
    ticks(win(2) - 1, 0);
    check("R5", 1'b0);
    ticks(1, 0);
    check("R5", 1'b1);

    // R4: read restarts the count
    cyc(1'b0, 1'b0, 1'b1);
    ticks(win(2) - 1, 0);
    check("R4", 1'b0);
    ticks(1, 0);
    check("R4", 1'b1);

    // R6: read and character together on the would-be final tick
    cyc(1'b0, 1'b0, 1'b1);
    ticks(win(2) - 1, 0);
    cyc(1'b1, 1'b1, 1'b1);
    check("R6", 1'b0);
    ticks(win(2) - 1, 0);
    check("R6", 1'b0);
    ticks(1, 0);
    check("R6", 1'b1);

    // R3: dropping either enable clears flag and count
    fifo_nonempty = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    check("R3", 1'b0);
    ticks(win(2) + 10, 0);
    check("R3", 1'b0);
    fifo_nonempty = 1'b1;
    ticks(win(2) - 1, 0);
    check("R3", 1'b0);
    ticks(1, 0);
    check("R3", 1'b1);
    fifo_mode = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    check("R3", 1'b0);
    ticks(win(2) + 10, 0);
    check("R3", 1'b0);
    fifo_mode = 1'b1;
    ticks(win(2) - 1, 0);
    check("R3", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule